// File: doc/BRIEF.md
# Single-Wire Slave ROM Command Engine

This block is the addressing layer of a slave device on a shared single-wire bus. A bit-slot layer below it handles the analog timing. That layer reports each bus reset and presence sequence, delivers each bit the master writes, and takes the bit the slave should return in each read slot. Once a bus reset has happened, the engine collects an 8-bit ROM command and carries it out against a 64-bit identity that is fixed at build time. When the command finishes successfully, the engine raises a grant. The grant unblocks the memory and switch command layer above it.

Five ROM functions are provided:

- read out the identity
- match a full identity sent by the master
- take part in a search
- skip addressing
- a conditional search, in which the slave takes part only while a chosen switch-side condition is true

The switch logic can also put the device into a hidden mode. In that mode only match and conditional search get a response.

Top module: `owrom_engine`

## Requirements
- R1: After the block reset and after every bus reset (`bus_rst` high for one cycle), `grant` is low, `tx_bit` is 1 (line released), and the next 8 written bits are taken as a ROM command.
- R2: A command is received least significant bit first. The codes are 33h read, 55h match, F0h search, CCh skip and ECh conditional search.
- R3: The identity sent on the bus is bit 0 first. Bits 0-7 hold the family code 12h, bits 8-55 hold the serial number, and bits 56-63 hold the CRC of bits 0-55. The CRC uses x^8+x^5+x^4+1, shifted in LSB first from a zero start.
- R4: After a read command, each read slot returns the next identity bit. `grant` rises after the 64th read slot.
- R5: After a match command, 64 written bits are compared with the identity. `grant` rises only if every bit is equal. Otherwise the block stays idle with `tx_bit` at 1 until the next bus reset.
- R6: A skip command raises `grant` right after the command byte, without any further slots.
- R7: During a search, each identity bit is handled in three slots. The first read slot returns the bit itself and the second returns its complement. The master then writes a bit. A written bit that differs from the identity bit sends the block idle, with `tx_bit` at 1 and no grant. After 64 agreeing bits, `grant` rises.
- R8: A conditional search behaves as a search only when the selected condition is true. `cond_sel` picks the condition: 0 means `pio_level` is high, 1 means `pio_on` is high, 2 means `activity` is high, and 3 means never. When the condition is false, the block goes idle with `tx_bit` at 1.
- R9: While `hidden` is high, read, search and skip commands are ignored. The line stays released and no grant is given. Match and conditional search still work.
- R10: Any other command code sends the block idle until the next bus reset, with no grant and `tx_bit` at 1.
- R11: A bus reset in the middle of any function aborts it. A new command is accepted afterwards.
- R12: Once raised, `grant` stays high through any later slots until a bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset |
| bus_rst | input | 1 | One-cycle pulse: the bus saw a reset and presence sequence |
| wr_stb | input | 1 | One-cycle pulse: a master write slot ended |
| wr_bit | input | 1 | Bit written by the master, valid with `wr_stb` |
| rd_stb | input | 1 | One-cycle pulse: a read slot consumed `tx_bit` |
| tx_bit | output | 1 | Bit to return in the next read slot (1 = release the line) |
| grant | output | 1 | ROM function completed; memory and switch commands are allowed |
| hidden | input | 1 | Hidden mode from the switch logic |
| cond_sel | input | 2 | Condition select for conditional search |
| pio_level | input | 1 | Sensed level of the switch pin |
| pio_on | input | 1 | State of the output transistor |
| activity | input | 1 | Latched activity flag |

## Verification
A wrong state or a wrong bit index shows up directly on `tx_bit` in the next read slot. Examples are a misdecoded command, an identity bit taken from the wrong position, or a search that keeps going after a mismatch. Each of these returns a bit that differs from the identity bit, its complement, or the released level. An error in the match comparison, or in the decision to take part in a conditional search, shows on `grant` at the end of the 64-bit sequence. It can also show earlier, as a line that stays driven when it should be released. A failure to clear on a bus reset appears on `grant` one cycle after the pulse.

// File: rtl/owrom_pkg.sv
package owrom_pkg;

   typedef enum logic [2:0] {
      ST_CMD,
      ST_READ,
      ST_MATCH,
      ST_SBIT,
      ST_SCMP,
      ST_SDIR,
      ST_GRANT,
      ST_IDLE
   } rom_st_t;

   localparam logic [7:0] OP_READ   = 8'h33;
   localparam logic [7:0] OP_MATCH  = 8'h55;
   localparam logic [7:0] OP_SEARCH = 8'hF0;
   localparam logic [7:0] OP_SKIP   = 8'hCC;
   localparam logic [7:0] OP_COND   = 8'hEC;

   // CRC x^8+x^5+x^4+1, reflected form, over the low nbits of d, LSB first
   function automatic logic [7:0] crc8_lsb(input logic [63:0] d, input int nbits);
      logic [7:0] c;
      logic       fb;
      c = 8'h00;
      for (int i = 0; i < 64; i++) begin
         if (i < nbits) begin
            fb = c[0] ^ d[i];
            c  = {1'b0, c[7:1]};
            if (fb) c = c ^ 8'h8C;
         end
      end
      return c;
   endfunction

endpackage

// File: rtl/owrom_cmd_rx.sv
module owrom_cmd_rx #(
   parameter int CMD_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic             wr_stb,
   input  logic             wr_bit,
   output logic             cmd_valid,
   output logic [CMD_W-1:0] cmd_code
);
   localparam int CNT_W = (CMD_W > 1) ? $clog2(CMD_W) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CMD_W - 1);

   logic [CNT_W-1:0] cnt;
   logic [CMD_W-1:0] sr;
   logic [CMD_W-1:0] sr_nxt;

   assign sr_nxt = {wr_bit, sr[CMD_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         sr        <= '0;
         cmd_valid <= 1'b0;
         cmd_code  <= '0;
      end else if (clr) begin
         cnt       <= '0;
         cmd_valid <= 1'b0;
      end else begin
         cmd_valid <= 1'b0;
         if (en && wr_stb) begin
            sr <= sr_nxt;
            if (cnt == CNT_LAST) begin
               cnt       <= '0;
               cmd_valid <= 1'b1;
               cmd_code  <= sr_nxt;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/owrom_cond.sv
module owrom_cond #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] cond_sel,
   input  logic       pio_level,
   input  logic       pio_on,
   input  logic       activity,
   output logic       cond_ok
);
   logic [2:0] raw;
   logic [2:0] cs;

   assign raw = {activity, pio_on, pio_level};

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign cs = raw;
      end else begin : g_sync
         logic [2:0] pipe [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < SYNC_STAGES; s++) pipe[s] <= '0;
            end else begin
               pipe[0] <= raw;
               for (int s = 1; s < SYNC_STAGES; s++) pipe[s] <= pipe[s-1];
            end
         end
         assign cs = pipe[SYNC_STAGES-1];
      end
   endgenerate

   always_comb begin
      case (cond_sel)
         2'd0:    cond_ok = cs[0];
         2'd1:    cond_ok = cs[1];
         2'd2:    cond_ok = cs[2];
         default: cond_ok = 1'b0;
      endcase
   end
endmodule

// File: rtl/owrom_id.sv
module owrom_id #(
   parameter int          FAM_W     = 8,
   parameter int          SER_W     = 48,
   parameter int          CRC_W     = 8,
   parameter logic [7:0]  FAMILY    = 8'h12,
   parameter logic [47:0] SERIAL    = 48'h0,
   parameter bit          CRC_CALC  = 1'b1,
   parameter logic [7:0]  CRC_FIXED = 8'h00,
   parameter int          IDX_W     = 6
) (
   input  logic [IDX_W-1:0] idx,
   output logic             id_bit
);
   import owrom_pkg::*;
   localparam int ID_W  = FAM_W + SER_W + CRC_W;
   localparam int HEAD_W = FAM_W + SER_W;
   localparam logic [63:0] HEAD = 64'({SERIAL[SER_W-1:0], FAMILY[FAM_W-1:0]});

   logic [CRC_W-1:0] crc;
   logic [ID_W-1:0]  id_vec;

   generate
      if (CRC_CALC) begin : g_crc_calc
         localparam logic [7:0] CRC_V = crc8_lsb(HEAD, HEAD_W);
         assign crc = CRC_V[CRC_W-1:0];
      end else begin : g_crc_fixed
         assign crc = CRC_FIXED[CRC_W-1:0];
      end
   endgenerate

   assign id_vec = {crc, HEAD[HEAD_W-1:0]};
   assign id_bit = id_vec[idx];
endmodule

// File: rtl/owrom_engine.sv
module owrom_engine #(
   parameter int          FAM_W       = 8,
   parameter int          SER_W       = 48,
   parameter int          CRC_W       = 8,
   parameter int          CMD_W       = 8,
   parameter logic [7:0]  FAMILY      = 8'h12,
   parameter logic [47:0] SERIAL      = 48'h0000_5A3C_91E7,
   parameter bit          CRC_CALC    = 1'b1,
   parameter logic [7:0]  CRC_FIXED   = 8'h00,
   parameter int          SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_rst,
   input  logic       wr_stb,
   input  logic       wr_bit,
   input  logic       rd_stb,
   output logic       tx_bit,
   output logic       grant,
   input  logic       hidden,
   input  logic [1:0] cond_sel,
   input  logic       pio_level,
   input  logic       pio_on,
   input  logic       activity
);
   import owrom_pkg::*;

   localparam int ID_W  = FAM_W + SER_W + CRC_W;
   localparam int IDX_W = $clog2(ID_W);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ID_W - 1);

   generate
      if (CRC_W != 8)  begin : g_bad_crc  $error("CRC_W must be 8"); end
      if (CMD_W != 8)  begin : g_bad_cmd  $error("CMD_W must be 8"); end
      if (ID_W != 64)  begin : g_bad_id   $error("identity must be 64 bits"); end
      if (FAM_W < 1 || FAM_W > 8) begin : g_bad_fam $error("FAM_W out of range"); end
      if (SYNC_STAGES < 0) begin : g_bad_sync $error("SYNC_STAGES negative"); end
   endgenerate

   rom_st_t          st;
   rom_st_t          st_cmd_nxt;
   logic [IDX_W-1:0] idx;
   logic             mism;
   logic             id_bit;
   logic             cmd_valid;
   logic [CMD_W-1:0] cmd_code;
   logic             cond_ok;
   logic             last;
   logic             bad_now;

   owrom_cmd_rx #(.CMD_W(CMD_W)) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (bus_rst),
      .en        (st == ST_CMD),
      .wr_stb    (wr_stb),
      .wr_bit    (wr_bit),
      .cmd_valid (cmd_valid),
      .cmd_code  (cmd_code)
   );

   owrom_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .cond_sel  (cond_sel),
      .pio_level (pio_level),
      .pio_on    (pio_on),
      .activity  (activity),
      .cond_ok   (cond_ok)
   );

   owrom_id #(
      .FAM_W(FAM_W), .SER_W(SER_W), .CRC_W(CRC_W), .FAMILY(FAMILY),
      .SERIAL(SERIAL), .CRC_CALC(CRC_CALC), .CRC_FIXED(CRC_FIXED), .IDX_W(IDX_W)
   ) u_id (
      .idx    (idx),
      .id_bit (id_bit)
   );

   assign last    = (idx == IDX_LAST);
   assign bad_now = (wr_bit != id_bit);

   always_comb begin
      case (cmd_code)
         OP_READ:   st_cmd_nxt = hidden ? ST_IDLE : ST_READ;
         OP_MATCH:  st_cmd_nxt = ST_MATCH;
         OP_SEARCH: st_cmd_nxt = hidden ? ST_IDLE : ST_SBIT;
         OP_SKIP:   st_cmd_nxt = hidden ? ST_IDLE : ST_GRANT;
         OP_COND:   st_cmd_nxt = cond_ok ? ST_SBIT : ST_IDLE;
         default:   st_cmd_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_CMD;
         idx  <= '0;
         mism <= 1'b0;
      end else if (bus_rst) begin
         st   <= ST_CMD;
         idx  <= '0;
         mism <= 1'b0;
      end else begin
         case (st)
            ST_CMD: begin
               if (cmd_valid) begin
                  st   <= st_cmd_nxt;
                  idx  <= '0;
                  mism <= 1'b0;
               end
            end
            ST_READ: begin
               if (rd_stb) begin
                  if (last) st  <= ST_GRANT;
                  else      idx <= idx + 1'b1;
               end
            end
            ST_MATCH: begin
               if (wr_stb) begin
                  if (last) begin
                     st <= (mism || bad_now) ? ST_IDLE : ST_GRANT;
                  end else begin
                     mism <= mism | bad_now;
                     idx  <= idx + 1'b1;
                  end
               end
            end
            ST_SBIT: if (rd_stb) st <= ST_SCMP;
            ST_SCMP: if (rd_stb) st <= ST_SDIR;
            ST_SDIR: begin
               if (wr_stb) begin
                  if (bad_now)   st <= ST_IDLE;
                  else if (last) st <= ST_GRANT;
                  else begin
                     idx <= idx + 1'b1;
                     st  <= ST_SBIT;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      case (st)
         ST_READ, ST_SBIT: tx_bit = id_bit;
         ST_SCMP:          tx_bit = ~id_bit;
         default:          tx_bit = 1'b1;
      endcase
   end

   assign grant = (st == ST_GRANT);
endmodule

// File: rtl/owrom_chk.sv
module owrom_chk
   import owrom_pkg::*;
(
   input logic    clk,
   input logic    rst_n,
   input logic    bus_rst,
   input logic    grant,
   input logic    tx_bit,
   input rom_st_t st,
   input logic    cmd_valid,
   input logic    mism
);
   a_r1_bus_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst |=> (!grant && tx_bit));

   a_r11_reset_to_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst |=> (st == ST_CMD));

   a_r12_grant_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && !bus_rst) |=> grant);

   a_r7_complement: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SCMP && $past(st) == ST_SBIT) |-> (tx_bit != $past(tx_bit)));

   a_r5_match_clean: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(grant) && $past(st) == ST_MATCH) |-> !$past(mism));

   a_r2_cmd_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);
endmodule

bind owrom_engine owrom_chk u_chk (.*);

// File: tb/tb_owrom_engine.sv
module tb_owrom_engine;
   localparam int CLK_P = 10;
   localparam logic [7:0]  FAM = 8'h12;
   localparam logic [47:0] SER = 48'hA1B2_C3D4_E5F6;
   localparam logic [7:0] C_READ = 8'h33, C_MATCH = 8'h55, C_SRCH = 8'hF0,
                          C_SKIP = 8'hCC, C_COND = 8'hEC;

   logic clk = 0, rst_n = 0, bus_rst = 0, wr_stb = 0, wr_bit = 0, rd_stb = 0;
   logic hidden = 0, pio_level = 0, pio_on = 0, activity = 0;
   logic [1:0] cond_sel = 2'd3;
   logic tx_bit, grant;
   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   always #(CLK_P/2) clk = ~clk;

   owrom_engine #(.SERIAL(SER)) dut (
      .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .wr_stb(wr_stb), .wr_bit(wr_bit),
      .rd_stb(rd_stb), .tx_bit(tx_bit), .grant(grant), .hidden(hidden),
      .cond_sel(cond_sel), .pio_level(pio_level), .pio_on(pio_on), .activity(activity)
   );

   function automatic logic [63:0] exp_id();
      logic [55:0] h;
      logic [7:0]  c;
      logic        f;
      h = {SER, FAM};
      c = 8'h00;
      for (int i = 0; i < 56; i++) begin
         f = c[0] ^ h[i];
         c = c >> 1;
         if (f) c ^= 8'h8C;
      end
      return {c, h};
   endfunction

   logic [63:0] ID;

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic b);
      @(negedge clk); wr_bit = b; wr_stb = 1;
      @(negedge clk); wr_stb = 0;
      repeat (2) @(negedge clk);
   endtask

   task automatic rd(output logic b);
      @(negedge clk); b = tx_bit; rd_stb = 1;
      @(negedge clk); rd_stb = 0;
      repeat (2) @(negedge clk);
   endtask

   task automatic breset();
      @(negedge clk); bus_rst = 1;
      @(negedge clk); bus_rst = 0;
      @(negedge clk);
   endtask

   task automatic cmd(input logic [7:0] c);
      for (int i = 0; i < 8; i++) wr(c[i]);
   endtask

   // full search; returns count of slot mismatches; diverge <0 means follow fully
   task automatic search(input int diverge, output int errs);
      logic b, cb;
      errs = 0;
      for (int i = 0; i < 64; i++) begin
         rd(b); rd(cb);
         if (i <= diverge || diverge < 0) begin
            if (b !== ID[i] || cb !== ~ID[i]) errs++;
         end else if (b !== 1'b1 || cb !== 1'b1) errs++;
         wr((i == diverge) ? ~ID[i] : ID[i]);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [63:0] v;
      logic b;
      int e, p;
      void'($urandom(32'd2024));
      ID = exp_id();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check(!grant && tx_bit, "R1 reset state", {grant, tx_bit}, 2'b01);

      // read identity
      breset(); cmd(C_READ);
      for (int i = 0; i < 64; i++) begin rd(b); v[i] = b; end
      check(v == ID, "R3 identity read LSB first", v, ID);
      check(v[7:0] == 8'h12, "R3 family code", v[7:0], 8'h12);
      check(grant, "R4 grant after read", grant, 1);
      breset();
      check(!grant, "R1 bus reset clears grant", grant, 0);

      // skip and hold
      cmd(C_SKIP);
      check(grant, "R6 skip grants", grant, 1);
      wr(1); wr(0); rd(b);
      check(grant, "R12 grant held", grant, 1);

      // match good
      breset(); cmd(C_MATCH);
      for (int i = 0; i < 64; i++) wr(ID[i]);
      check(grant, "R5 match all equal", grant, 1);

      // match with a single wrong bit
      for (int k = 0; k < 4; k++) begin
         p = (k == 0) ? 63 : int'($urandom_range(0, 63));
         breset(); cmd(C_MATCH);
         for (int i = 0; i < 64; i++) wr((i == p) ? ~ID[i] : ID[i]);
         rd(b);
         check(!grant && b, $sformatf("R5 match mismatch at %0d", p), {grant, b}, 2'b01);
      end

      // full search
      breset(); cmd(C_SRCH); search(-1, e);
      check(e == 0 && grant, "R7 search full path", e, 0);

      // diverging searches
      for (int k = 0; k < 3; k++) begin
         p = (k == 0) ? 0 : int'($urandom_range(1, 63));
         breset(); cmd(C_SRCH); search(p, e);
         check(e == 0 && !grant, $sformatf("R7 search diverge at %0d", p), {e, grant}, 0);
      end

      // conditional search, all selects both ways
      for (int s = 0; s < 4; s++) begin
         for (int t = 0; t < 2; t++) begin
            cond_sel = 2'(s);
            pio_level = (s == 0) ? t[0] : ~t[0];
            pio_on    = (s == 1) ? t[0] : ~t[0];
            activity  = (s == 2) ? t[0] : ~t[0];
            breset(); cmd(C_COND);
            if (s < 3 && t == 1) begin
               search(-1, e);
               check(e == 0 && grant, $sformatf("R8 cond sel %0d true", s), e, 0);
            end else begin
               rd(b);
               check(b && !grant, $sformatf("R8 cond sel %0d false", s), {b, grant}, 2'b10);
            end
         end
      end

      // hidden mode
      hidden = 1;
      breset(); cmd(C_READ); rd(b);
      check(b && !grant, "R9 hidden read ignored", {b, grant}, 2'b10);
      breset(); cmd(C_SKIP);
      check(!grant, "R9 hidden skip ignored", grant, 0);
      breset(); cmd(C_SRCH); rd(b);
      check(b && !grant, "R9 hidden search ignored", {b, grant}, 2'b10);
      breset(); cmd(C_MATCH);
      for (int i = 0; i < 64; i++) wr(ID[i]);
      check(grant, "R9 hidden match works", grant, 1);
      cond_sel = 2'd2; activity = 1;
      breset(); cmd(C_COND); search(-1, e);
      check(e == 0 && grant, "R9 hidden cond search works", e, 0);
      hidden = 0;

      // unknown codes
      for (int k = 0; k < 3; k++) begin
         logic [7:0] c;
         do c = 8'($urandom);
         while (c == C_READ || c == C_MATCH || c == C_SRCH || c == C_SKIP || c == C_COND);
         breset(); cmd(c); rd(b);
         check(b && !grant, $sformatf("R10 unknown code %h", c), {b, grant}, 2'b10);
      end

      // reset mid-function
      p = int'($urandom_range(1, 62));
      breset(); cmd(C_MATCH);
      for (int i = 0; i < p; i++) wr(ID[i]);
      breset(); cmd(C_SKIP);
      check(grant, "R11 abort match then skip", grant, 1);
      breset(); cmd(C_READ);
      for (int i = 0; i < 5; i++) rd(b);
      breset(); cmd(C_READ); rd(b);
      check(b == ID[0], "R11 abort read restarts at bit 0", b, ID[0]);
      check(!grant, "R2 command accepted after abort", grant, 0);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule